// File: doc/BRIEF.md
# Power-Down and Resume Sequencer

This block controls the global low-power state of a synthesizer device. On the host side it takes byte writes to a command register and a control register, and it presents a status byte that the host polls. A single-cycle trigger from a system-exclusive message decoder can also request power-down.

A power-down request starts a timed entry sequence. The synthesizer clock enable drops first. One cycle later the busy flag clears. The block then waits a set number of slow ticks before it reports full power-down and pulls its active-low power-down output low. While powered down, the command path and the message trigger are locked out. Only a control write with both wake bits set starts recovery. Recovery then waits for a settle interval, and an input chosen at the recovery write selects which interval applies: the longer one when a crystal oscillator must restart, the shorter one when only the internal clock generator must restart. When the wait completes the block returns to normal operation with the clock enabled and busy set again.

All delays are counted on `tick_i`, a one-cycle strobe from a free-running low-rate time base. The tick counts are parameters, and each must be at least 1.

Top module: `pdn_sequencer`

## Requirements
- R1: After reset the state code is 0 (run), `synth_clk_en_o` is 1, `pdout_no` is 1 and `status_o` reads 8'h80.
- R2: In run state, a command write of `PD_CODE` (default 8'hFD) moves the block to state code 1 on the next clock. A command write of any other value has no effect.
- R3: In run state, a one-cycle pulse on `sysex_pd_i` starts the same entry sequence as R2.
- R4: In state 1 (gate) the clock enable is 0 while busy is still 1. State 1 lasts exactly one cycle and is followed by state 2 (entry wait), where busy is 0.
- R5: State 2 lasts until exactly `ENTRY_TICKS` ticks have been seen in it, then the block enters state 3 (powered down). `pdout_no` is 0 in state 3 and only in state 3.
- R6: In state 3, command writes of any value, including `PD_CODE`, and `sysex_pd_i` pulses have no effect. A control write with only one of bits [1:0] set also has no effect.
- R7: In state 3, a control write with bits [1:0] equal to 2'b11 (the `WAKE_MASK` default) moves the block to state 4 (resume wait) on the next clock. In state 4, `pdout_no` is 1, the clock enable is 0 and busy is 0.
- R8: State 4 lasts exactly `XTAL_TICKS` ticks if `xtal_mode_i` was 1 at the recovery write, and `CLK_TICKS` ticks if it was 0. The block then returns to state 0 with the clock enable at 1 and busy at 1.
- R9: Power-down triggers that arrive in states 1, 2 or 4 are dropped and not queued. After resume the block stays in state 0 until a new trigger arrives.
- R10: Control writes outside state 3 have no effect.
- R11: `status_o` holds busy in bit 7 and the state code in bits [2:0]. Bits [6:3] always read 0, and the state code never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Low-rate time base strobe, one cycle wide |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_data_i | input | 8 | Command write data |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_data_i | input | 8 | Control write data; bits [1:0] are the wake bits |
| sysex_pd_i | input | 1 | Power-down request pulse from message decoder |
| xtal_mode_i | input | 1 | 1 selects the crystal settle delay, 0 selects the clock-restart delay |
| synth_clk_en_o | output | 1 | Synthesizer clock enable |
| pdout_no | output | 1 | Power-down indication, active low |
| status_o | output | 8 | Status byte: busy in bit 7, state code in bits [2:0] |

## Verification
The hardest conditions to reach are a trigger that arrives while a wait is already counting, and the settle length being fixed by the mode input at the moment of the recovery write rather than later. The stimulus fires a message pulse and a power-down command in the middle of both the entry wait and the resume wait. It also toggles `xtal_mode_i` right after the recovery write. The bench counts the ticks it sees in each wait state and checks them against the selected parameter. A reference model that advances tick by tick is compared against the outputs on every clock.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_RUN    = 3'd0,
    ST_GATE   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_DOWN   = 3'd3,
    ST_RESUME = 3'd4
  } pdn_state_e;
endpackage

// File: rtl/pdn_cmd_dec.sv
module pdn_cmd_dec #(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  PD_CODE   = 8'hFD,
  parameter logic [7:0]  WAKE_MASK = 8'h03
) (
  input  logic              cmd_we_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              ctl_we_i,
  input  logic [DATA_W-1:0] ctl_data_i,
  input  logic              sysex_pd_i,
  output logic              pd_req_o,
  output logic              wake_req_o
);
  localparam logic [DATA_W-1:0] CODE = DATA_W'(PD_CODE);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(WAKE_MASK);

  always_comb begin
    pd_req_o   = (cmd_we_i && (cmd_data_i == CODE)) || sysex_pd_i;
    wake_req_o = ctl_we_i && ((ctl_data_i & MASK) == MASK);
  end
endmodule

// File: rtl/pdn_timer.sv
module pdn_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (load_i)                          cnt_q <= limit_i;
    else if (run_i && tick_i && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  // last tick of the window ends it on the same edge
  assign done_o = run_i && tick_i && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
  import pdn_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_req_i,
  input  logic       wake_req_i,
  input  logic       done_i,
  output logic       load_o,
  output logic       load_settle_o,
  output logic       run_o,
  output logic       clk_en_o,
  output logic       pdout_no,
  output logic       busy_o,
  output pdn_state_e state_o
);
  pdn_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (pd_req_i)   state_d = ST_GATE;
      ST_GATE:                   state_d = ST_WAIT;
      ST_WAIT:   if (done_i)     state_d = ST_DOWN;
      ST_DOWN:   if (wake_req_i) state_d = ST_RESUME;
      ST_RESUME: if (done_i)     state_d = ST_RUN;
      default:                   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  always_comb begin
    load_settle_o = (state_q == ST_DOWN) && wake_req_i;
    load_o        = (state_q == ST_GATE) || load_settle_o;
    run_o         = (state_q == ST_WAIT) || (state_q == ST_RESUME);
    clk_en_o      = (state_q == ST_RUN);
    pdout_no      = (state_q != ST_DOWN);
    busy_o        = (state_q == ST_RUN) || (state_q == ST_GATE);
  end

  assign state_o = state_q;
endmodule

// File: rtl/pdn_sequencer.sv
module pdn_sequencer
  import pdn_pkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter logic [7:0] PD_CODE     = 8'hFD,
  parameter logic [7:0] WAKE_MASK   = 8'h03,
  parameter int         ENTRY_TICKS = 30,
  parameter int         XTAL_TICKS  = 75,
  parameter int         CLK_TICKS   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmd_we_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              ctl_we_i,
  input  logic [DATA_W-1:0] ctl_data_i,
  input  logic              sysex_pd_i,
  input  logic              xtal_mode_i,
  output logic              synth_clk_en_o,
  output logic              pdout_no,
  output logic [7:0]        status_o
);
  localparam int MAX_A  = (ENTRY_TICKS > XTAL_TICKS) ? ENTRY_TICKS : XTAL_TICKS;
  localparam int MAX_T  = (MAX_A > CLK_TICKS) ? MAX_A : CLK_TICKS;
  localparam int CNT_W  = $clog2(MAX_T + 1);
  localparam int PAD_W  = 8 - 1 - STATE_W;

  logic             pd_req, wake_req, done, load, load_settle, run, busy;
  logic [CNT_W-1:0] limit;
  pdn_state_e       state;

  pdn_cmd_dec #(
    .DATA_W(DATA_W), .PD_CODE(PD_CODE), .WAKE_MASK(WAKE_MASK)
  ) u_dec (
    .cmd_we_i  (cmd_we_i),
    .cmd_data_i(cmd_data_i),
    .ctl_we_i  (ctl_we_i),
    .ctl_data_i(ctl_data_i),
    .sysex_pd_i(sysex_pd_i),
    .pd_req_o  (pd_req),
    .wake_req_o(wake_req)
  );

  always_comb begin
    if (!load_settle)     limit = CNT_W'(ENTRY_TICKS);
    else if (xtal_mode_i) limit = CNT_W'(XTAL_TICKS);
    else                  limit = CNT_W'(CLK_TICKS);
  end

  pdn_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .limit_i(limit),
    .run_i  (run),
    .tick_i (tick_i),
    .done_o (done)
  );

  pdn_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pd_req_i     (pd_req),
    .wake_req_i   (wake_req),
    .done_i       (done),
    .load_o       (load),
    .load_settle_o(load_settle),
    .run_o        (run),
    .clk_en_o     (synth_clk_en_o),
    .pdout_no     (pdout_no),
    .busy_o       (busy),
    .state_o      (state)
  );

  assign status_o = {busy, {PAD_W{1'b0}}, state};
endmodule

// File: rtl/pdn_checker.sv
module pdn_checker #(
  parameter int         DATA_W    = 8,
  parameter logic [7:0] PD_CODE   = 8'hFD,
  parameter logic [7:0] WAKE_MASK = 8'h03
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_we_i,
  input logic [DATA_W-1:0] cmd_data_i,
  input logic              ctl_we_i,
  input logic [DATA_W-1:0] ctl_data_i,
  input logic              synth_clk_en_o,
  input logic              pdout_no,
  input logic [7:0]        status_o
);
  logic [2:0] st;
  logic       busy, wake, fd;
  assign st   = status_o[2:0];
  assign busy = status_o[7];
  assign wake = ctl_we_i && ((ctl_data_i & DATA_W'(WAKE_MASK)) == DATA_W'(WAKE_MASK));
  assign fd   = cmd_we_i && (cmd_data_i == DATA_W'(PD_CODE));

  assert_fd_enters_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == 3'd0 && fd) |=> (st == 3'd1));

  assert_gate_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(synth_clk_en_o) |-> busy ##1 !busy);

  assert_pdout_only_down_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdout_no |-> (st == 3'd3 && !synth_clk_en_o && !busy));

  assert_down_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == 3'd3 && !wake) |=> (st == 3'd3));

  assert_wake_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == 3'd3 && wake) |=> (st == 3'd4 && pdout_no));

  assert_busy_return_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> (st == 3'd0 && synth_clk_en_o));

  assert_resume_no_requeue_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == 3'd4) |=> (st == 3'd4 || st == 3'd0));

  assert_status_legal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[6:3] == 4'd0) && (st <= 3'd4));
endmodule

bind pdn_sequencer pdn_checker #(
  .DATA_W(DATA_W), .PD_CODE(PD_CODE), .WAKE_MASK(WAKE_MASK)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_we_i      (cmd_we_i),
  .cmd_data_i    (cmd_data_i),
  .ctl_we_i      (ctl_we_i),
  .ctl_data_i    (ctl_data_i),
  .synth_clk_en_o(synth_clk_en_o),
  .pdout_no      (pdout_no),
  .status_o      (status_o)
);

// File: tb/pdn_sequencer_test.sv
`timescale 1ns/1ps
module pdn_sequencer_test;
  localparam int ENTRY = 5;
  localparam int XTAL  = 9;
  localparam int CLKR  = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic cmd_we = 1'b0, ctl_we = 1'b0, sysex = 1'b0, xtal = 1'b0;
  logic [7:0] cmd_data = 8'h00, ctl_data = 8'h00;
  logic clk_en, pdout_n;
  logic [7:0] status;

  int checks = 0, fails = 0, wait_ticks = 0, res_ticks = 0, tcnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pdn_sequencer #(.ENTRY_TICKS(ENTRY), .XTAL_TICKS(XTAL), .CLK_TICKS(CLKR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .cmd_we_i(cmd_we), .cmd_data_i(cmd_data),
    .ctl_we_i(ctl_we), .ctl_data_i(ctl_data),
    .sysex_pd_i(sysex), .xtal_mode_i(xtal),
    .synth_clk_en_o(clk_en), .pdout_no(pdout_n), .status_o(status)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: mode number and remaining ticks
  int m_st = 0, m_left = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_left = 0;
    end else begin
      if (m_st == 0) begin
        if ((cmd_we && cmd_data == 8'hFD) || sysex) m_st = 1;
      end else if (m_st == 1) begin
        m_st = 2; m_left = ENTRY;
      end else if (m_st == 2) begin
        if (tick) begin m_left--; if (m_left == 0) m_st = 3; end
      end else if (m_st == 3) begin
        if (ctl_we && ctl_data[1:0] == 2'b11) begin m_st = 4; m_left = xtal ? XTAL : CLKR; end
      end else begin
        if (tick) begin m_left--; if (m_left == 0) m_st = 0; end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    check("R5 model pdout_no", pdout_n, (m_st != 3));
    check("R4 model clk_en", clk_en, (m_st == 0));
    check("R11 model status", status, {(m_st <= 1), 4'b0, 3'(m_st)});
  end

  always @(posedge clk) begin
    if (status[2:0] == 3'd2 && tick) wait_ticks++;
    if (status[2:0] == 3'd4 && tick) res_ticks++;
  end

  initial forever begin
    @(negedge clk); tcnt++; tick = (tcnt % 3 == 0);
  end

  task automatic cmd_wr(input logic [7:0] d);
    @(negedge clk); cmd_we = 1; cmd_data = d;
    @(negedge clk); cmd_we = 0;
  endtask
  task automatic ctl_wr(input logic [7:0] d);
    @(negedge clk); ctl_we = 1; ctl_data = d;
    @(negedge clk); ctl_we = 0;
  endtask
  task automatic sysex_pulse();
    @(negedge clk); sysex = 1;
    @(negedge clk); sysex = 0;
  endtask
  task automatic wait_code(input int code);
    for (int i = 0; i < 500 && status[2:0] != 3'(code); i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 status", status, 8'h80);
    check("R1 clk_en", clk_en, 1);
    check("R1 pdout_no", pdout_n, 1);

    cmd_wr(8'h3A);
    check("R2 other code ignored", status, 8'h80);
    ctl_wr(8'h03);
    check("R10 ctl in run ignored", status, 8'h80);

    wait_ticks = 0;
    cmd_wr(8'hFD);
    check("R2 fd enters gate", status, 8'h81);
    check("R4 clock gated first", clk_en, 0);
    @(negedge clk);
    check("R4 busy cleared", status, 8'h02);
    sysex_pulse();
    cmd_wr(8'hFD);
    ctl_wr(8'h03);
    check("R9 trigger in wait dropped", status[2:0], 2);
    wait_code(3);
    check("R5 entry tick count", wait_ticks, ENTRY);
    check("R5 pdout low", pdout_n, 0);

    cmd_wr(8'hFD); cmd_wr(8'h00); sysex_pulse();
    ctl_wr(8'h01); ctl_wr(8'h02);
    check("R6 locked in down", status, 8'h03);
    check("R6 pdout still low", pdout_n, 0);

    res_ticks = 0;
    xtal = 1;
    ctl_wr(8'hF3);
    xtal = 0;
    check("R7 resume state", status, 8'h04);
    check("R7 pdout high", pdout_n, 1);
    check("R7 clk still gated", clk_en, 0);
    sysex_pulse(); cmd_wr(8'hFD);
    wait_code(0);
    check("R8 xtal settle ticks", res_ticks, XTAL);
    check("R8 back to run", status, 8'h80);
    check("R8 clk enabled", clk_en, 1);
    repeat (10) @(negedge clk);
    check("R9 not queued", status, 8'h80);

    sysex_pulse();
    check("R3 sysex enters gate", status, 8'h81);
    wait_code(3);
    res_ticks = 0;
    xtal = 0;
    ctl_wr(8'h03);
    xtal = 1;
    wait_code(0);
    check("R8 clk restart ticks", res_ticks, CLKR);
    check("R8 run again", status, 8'h80);

    cmd_wr(8'hFD);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R1 async reset mid entry", status, 8'h80);
    check("R1 async reset pdout", pdout_n, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 stays run after reset", status, 8'h80);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule